// File: doc/BRIEF.md
# Gradient Edge Direction Histogram for 4x4 Luma Blocks

This block receives one 4x4 block of 8-bit luma samples per cycle and estimates which way its edges run. It slides a 2x2 window over the block, so it uses only samples inside the block and never waits for pixels from a neighbouring block. Each of the nine window positions gives a horizontal and a vertical gradient. The block then matches each gradient to the nearest of eight directions. The matching uses only shifted copies of the vertical magnitude, so there are no multipliers or dividers.

The gradient amplitude |Gx|+|Gy| goes into the histogram bin of the matched direction. When the block finishes, it presents all eight bins and the index of the strongest bin. A mode-decision stage downstream uses these results to cut down the set of intra prediction candidates it must evaluate. The block is fully pipelined: it accepts a new block on every cycle and returns each result a fixed four cycles later.

Top module: `edir_estimator`

## Requirements
- R1: The sample at column c and row r (both 0..3) sits at bits [(4*r+c)*8 +: 8] of `blk_pix_i` and is read as unsigned.
- R2: There are nine gradients, one per window whose top-left corner is at (c,r) with c,r in 0..2. With tl=f(c,r), tr=f(c+1,r), bl=f(c,r+1) and br=f(c+1,r+1): Gx = tr+br-tl-bl and Gy = tl+tr-br-bl.
- R3: Each gradient adds |Gx|+|Gy| to exactly one bin. Bin n sits at bits [n*14 +: 14] of `res_bins_o`. A bin can hold nine full-scale amplitudes (at most 4590) without wrapping.
- R4: The error for direction n is | |Gx| - s_n(|Gy|) |. The scaled value s_n is |Gy|<<3 for n=0, |Gy|>>3 for n=1, |Gy| for n=2 and n=3, |Gy|<<1 for n=4 and n=6, and |Gy|>>1 for n=5 and n=7. Right shifts round down.
- R5: Directions 0 and 1 are always candidates. Directions 2, 4 and 5 are candidates only when Gx and Gy have the same sign. Directions 3, 6 and 7 are candidates only when the signs differ. A zero value counts as non-negative.
- R6: Each gradient takes the candidate with the smallest error. When errors are equal, the lowest index wins.
- R7: `res_dir_o` holds the index of the largest bin. Equal bins go to the lower index, and an all-zero histogram reports 0.
- R8: A block accepted on a clock edge with `blk_vld_i` high raises `res_vld_o` for one cycle, four edges later. Blocks may arrive back to back.
- R9: After reset, `res_vld_o` is 0, every bin is 0 and `res_dir_o` is 0.
- R10: Samples presented while `blk_vld_i` is low are ignored. They produce no result pulse and leave the presented bins and index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_vld_i | input | 1 | A block is present on `blk_pix_i` |
| blk_pix_i | input | 128 | Sixteen 8-bit samples, row-major |
| res_vld_o | output | 1 | Result pulse for one block |
| res_bins_o | output | 112 | Eight 14-bit amplitude bins |
| res_dir_o | output | 3 | Index of the strongest bin |

## Verification
Because the pipeline is four blocks deep, a new block can be accepted on the same edge that an earlier block's histogram is summed and a still earlier block's result is presented. The stimulus therefore uses long runs of back-to-back valid cycles, with idle gaps mixed in. A behavioural model compares the valid pulse, the bins and the index on every cycle. Tie handling is provoked in two places: directed blocks where all direction errors are equal, and blocks where two bins hold the same total. Ramp patterns with various slopes steer gradients toward every shift ratio.

// File: rtl/edir_pkg.sv
package edir_pkg;
  parameter int PIX_W = 8;
  parameter int DIM   = 4;
  localparam int NPIX    = DIM * DIM;
  localparam int GDIM    = DIM - 1;
  localparam int NGRAD   = GDIM * GDIM;
  localparam int NDIR    = 8;
  localparam int DIR_W   = $clog2(NDIR);
  localparam int GRAD_W  = PIX_W + 2;
  localparam int MAG_W   = PIX_W + 1;
  localparam int AMP_W   = PIX_W + 2;
  localparam int BIN_W   = AMP_W + $clog2(NGRAD);
  localparam int ERR_W   = MAG_W + 4;
  localparam int LATENCY = 4;
  localparam int AMP_MAX = 2 * ((1 << PIX_W) - 1);

  typedef logic [PIX_W-1:0]         pix_t;
  typedef logic signed [GRAD_W-1:0] grad_t;
  typedef logic [MAG_W-1:0]         mag_t;
  typedef logic [AMP_W-1:0]         amp_t;
  typedef logic [ERR_W-1:0]         err_t;
  typedef logic [BIN_W-1:0]         bin_t;
  typedef logic [DIR_W-1:0]         dir_t;

  function automatic grad_t widen(input pix_t p);
    return grad_t'({2'b00, p});
  endfunction

  // Right column pair minus left column pair.
  function automatic grad_t grad_x(input pix_t tl, input pix_t tr,
                                   input pix_t bl, input pix_t br);
    return (widen(tr) + widen(br)) - (widen(tl) + widen(bl));
  endfunction

  // Top-left/top-right minus bottom pair.
  function automatic grad_t grad_y(input pix_t tl, input pix_t tr,
                                   input pix_t bl, input pix_t br);
    return (widen(tl) + widen(tr)) - (widen(br) + widen(bl));
  endfunction

  function automatic mag_t magnitude(input grad_t g);
    grad_t p;
    p = g[GRAD_W-1] ? -g : g;
    return p[MAG_W-1:0];
  endfunction

  function automatic amp_t amplitude(input grad_t gx, input grad_t gy);
    return amp_t'(magnitude(gx)) + amp_t'(magnitude(gy));
  endfunction

  // Power-of-two slope per direction; shifts only.
  function automatic err_t slope_scale(input dir_t n, input mag_t m);
    err_t e;
    e = err_t'(m);
    case (n)
      3'd0:       return e << 3;
      3'd1:       return e >> 3;
      3'd2, 3'd3: return e;
      3'd4, 3'd6: return e << 1;
      default:    return e >> 1;
    endcase
  endfunction

  function automatic err_t dir_error(input dir_t n, input mag_t ax, input mag_t ay);
    err_t s;
    err_t x;
    s = slope_scale(n, ay);
    x = err_t'(ax);
    return (x >= s) ? (x - s) : (s - x);
  endfunction

  // Paired slopes split by sign agreement: low index for agreeing signs.
  function automatic logic dir_permitted(input dir_t n, input logic same);
    case (n)
      3'd0, 3'd1:       return 1'b1;
      3'd2, 3'd4, 3'd5: return same;
      default:          return !same;
    endcase
  endfunction

  function automatic dir_t pick_dir(input grad_t gx, input grad_t gy);
    mag_t ax;
    mag_t ay;
    logic same;
    dir_t best;
    err_t best_e;
    err_t e;
    ax     = magnitude(gx);
    ay     = magnitude(gy);
    same   = (gx[GRAD_W-1] == gy[GRAD_W-1]);
    best   = '0;
    best_e = '1;
    for (int n = 0; n < NDIR; n++) begin
      e = dir_error(dir_t'(n), ax, ay);
      if (dir_permitted(dir_t'(n), same) && (e < best_e)) begin
        best   = dir_t'(n);
        best_e = e;
      end
    end
    return best;
  endfunction
endpackage

// File: rtl/edir_grad_stage.sv
module edir_grad_stage
  import edir_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         vld_i,
  input  logic [NPIX*PIX_W-1:0]        pix_i,
  output logic                         vld_o,
  output logic [NGRAD-1:0][GRAD_W-1:0] gx_o,
  output logic [NGRAD-1:0][GRAD_W-1:0] gy_o
);
  logic [NGRAD-1:0][GRAD_W-1:0] gx_n;
  logic [NGRAD-1:0][GRAD_W-1:0] gy_n;

  for (genvar gr = 0; gr < GDIM; gr++) begin : g_row
    for (genvar gc = 0; gc < GDIM; gc++) begin : g_col
      localparam int G  = gr * GDIM + gc;
      localparam int TL = (gr * DIM + gc) * PIX_W;
      localparam int TR = TL + PIX_W;
      localparam int BL = TL + DIM * PIX_W;
      localparam int BR = BL + PIX_W;
      assign gx_n[G] = grad_x(pix_i[TL +: PIX_W], pix_i[TR +: PIX_W],
                              pix_i[BL +: PIX_W], pix_i[BR +: PIX_W]);
      assign gy_n[G] = grad_y(pix_i[TL +: PIX_W], pix_i[TR +: PIX_W],
                              pix_i[BL +: PIX_W], pix_i[BR +: PIX_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      gx_o  <= '0;
      gy_o  <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        gx_o <= gx_n;
        gy_o <= gy_n;
      end
    end
  end
endmodule

// File: rtl/edir_dir_stage.sv
module edir_dir_stage
  import edir_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         vld_i,
  input  logic [NGRAD-1:0][GRAD_W-1:0] gx_i,
  input  logic [NGRAD-1:0][GRAD_W-1:0] gy_i,
  output logic                         vld_o,
  output logic [NGRAD-1:0][DIR_W-1:0]  dir_o,
  output logic [NGRAD-1:0][AMP_W-1:0]  amp_o
);
  logic [NGRAD-1:0][DIR_W-1:0] dir_n;
  logic [NGRAD-1:0][AMP_W-1:0] amp_n;

  for (genvar g = 0; g < NGRAD; g++) begin : g_cls
    assign dir_n[g] = pick_dir(gx_i[g], gy_i[g]);
    assign amp_n[g] = amplitude(gx_i[g], gy_i[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      dir_o <= '0;
      amp_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        dir_o <= dir_n;
        amp_o <= amp_n;
      end
    end
  end
endmodule

// File: rtl/edir_hist_stage.sv
module edir_hist_stage
  import edir_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        vld_i,
  input  logic [NGRAD-1:0][DIR_W-1:0] dir_i,
  input  logic [NGRAD-1:0][AMP_W-1:0] amp_i,
  output logic                        vld_o,
  output logic [NDIR-1:0][BIN_W-1:0]  bins_o
);
  logic [NDIR-1:0][BIN_W-1:0] bins_n;

  function automatic bin_t bin_sum(input dir_t d,
                                   input logic [NGRAD-1:0][DIR_W-1:0] dirs,
                                   input logic [NGRAD-1:0][AMP_W-1:0] amps);
    bin_t acc;
    acc = '0;
    for (int g = 0; g < NGRAD; g++)
      if (dirs[g] == d) acc = acc + bin_t'(amps[g]);
    return acc;
  endfunction

  for (genvar d = 0; d < NDIR; d++) begin : g_bin
    assign bins_n[d] = bin_sum(dir_t'(d), dir_i, amp_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      bins_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) bins_o <= bins_n;
    end
  end
endmodule

// File: rtl/edir_argmax_stage.sv
module edir_argmax_stage
  import edir_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       vld_i,
  input  logic [NDIR-1:0][BIN_W-1:0] bins_i,
  output logic                       vld_o,
  output logic [NDIR-1:0][BIN_W-1:0] bins_o,
  output logic [DIR_W-1:0]           best_o
);
  dir_t best_n;
  bin_t best_v;

  // Strict compare keeps the earliest index on equal totals.
  always_comb begin
    best_n = '0;
    best_v = bins_i[0];
    for (int n = 1; n < NDIR; n++) begin
      if (bins_i[n] > best_v) begin
        best_n = dir_t'(n);
        best_v = bins_i[n];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      bins_o <= '0;
      best_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        bins_o <= bins_i;
        best_o <= best_n;
      end
    end
  end
endmodule

// File: rtl/edir_estimator.sv
module edir_estimator
  import edir_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    blk_vld_i,
  input  logic [NPIX*PIX_W-1:0]   blk_pix_i,
  output logic                    res_vld_o,
  output logic [NDIR*BIN_W-1:0]   res_bins_o,
  output logic [DIR_W-1:0]        res_dir_o
);
  // Stage events, brought out for the checker.
  logic grad_vld;
  logic cls_vld;
  logic hist_vld;

  logic [NGRAD-1:0][GRAD_W-1:0] gx_q;
  logic [NGRAD-1:0][GRAD_W-1:0] gy_q;
  logic [NGRAD-1:0][DIR_W-1:0]  dir_q;
  logic [NGRAD-1:0][AMP_W-1:0]  amp_q;
  logic [NDIR-1:0][BIN_W-1:0]   hist_q;
  logic [NDIR-1:0][BIN_W-1:0]   bins_q;

  edir_grad_stage u_grad (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (blk_vld_i),
    .pix_i (blk_pix_i),
    .vld_o (grad_vld),
    .gx_o  (gx_q),
    .gy_o  (gy_q)
  );

  edir_dir_stage u_dir (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (grad_vld),
    .gx_i  (gx_q),
    .gy_i  (gy_q),
    .vld_o (cls_vld),
    .dir_o (dir_q),
    .amp_o (amp_q)
  );

  edir_hist_stage u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (cls_vld),
    .dir_i  (dir_q),
    .amp_i  (amp_q),
    .vld_o  (hist_vld),
    .bins_o (hist_q)
  );

  edir_argmax_stage u_max (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (hist_vld),
    .bins_i (hist_q),
    .vld_o  (res_vld_o),
    .bins_o (bins_q),
    .best_o (res_dir_o)
  );

  assign res_bins_o = bins_q;
endmodule

// File: rtl/edir_estimator_chk.sv
module edir_estimator_chk
  import edir_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  blk_vld_i,
  input logic                  hist_vld,
  input logic                  res_vld_o,
  input logic [NDIR*BIN_W-1:0] res_bins_o,
  input logic [DIR_W-1:0]      res_dir_o
);
  int unsigned since_rst;
  logic        max_ok;
  logic        all_zero;
  int unsigned total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 0;
    else if (since_rst < LATENCY) since_rst <= since_rst + 1;
  end

  always_comb begin
    bin_t top;
    top      = res_bins_o[res_dir_o*BIN_W +: BIN_W];
    max_ok   = 1'b1;
    all_zero = 1'b1;
    total    = 0;
    for (int n = 0; n < NDIR; n++) begin
      bin_t v;
      v     = res_bins_o[n*BIN_W +: BIN_W];
      total = total + int'(v);
      if (v != '0) all_zero = 1'b0;
      if (v > top) max_ok = 1'b0;
      if ((n < int'(res_dir_o)) && (v == top)) max_ok = 1'b0;
    end
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == LATENCY) |-> (res_vld_o == $past(blk_vld_i, LATENCY)));

  assert_hist_to_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hist_vld |=> res_vld_o);

  assert_best_is_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> max_ok);

  assert_zero_hist_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && all_zero) |-> (res_dir_o == '0));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> (total <= NGRAD * AMP_MAX));
endmodule

bind edir_estimator edir_estimator_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .blk_vld_i  (blk_vld_i),
  .hist_vld   (hist_vld),
  .res_vld_o  (res_vld_o),
  .res_bins_o (res_bins_o),
  .res_dir_o  (res_dir_o)
);

// File: tb/edir_estimator_tb_top.sv
`timescale 1ns/1ps
module edir_estimator_tb_top;
  import edir_pkg::*;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  blk_vld_i = 1'b0;
  logic [NPIX*PIX_W-1:0] blk_pix_i = '0;
  logic                  res_vld_o;
  logic [NDIR*BIN_W-1:0] res_bins_o;
  logic [DIR_W-1:0]      res_dir_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_on = 0;

  logic [NPIX*PIX_W-1:0] vec;
  int m_vld [4];
  int m_dir [4];
  int m_bins [4][8];

  always #10 clk = ~clk;

  edir_estimator dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk_vld_i  (blk_vld_i),
    .blk_pix_i  (blk_pix_i),
    .res_vld_o  (res_vld_o),
    .res_bins_o (res_bins_o),
    .res_dir_o  (res_dir_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int bin_of(input int n);
    return int'(res_bins_o[n*BIN_W +: BIN_W]);
  endfunction

  function automatic int px(input logic [NPIX*PIX_W-1:0] v, input int c, input int r);
    return int'(v[(r*DIM+c)*PIX_W +: PIX_W]);
  endfunction

  // Behavioural model: integer arithmetic with real multiply/divide.
  task automatic model_calc(input logic [NPIX*PIX_W-1:0] v);
    int k_mul [8] = '{8, 1, 1, 1, 2, 1, 2, 1};
    int k_div [8] = '{1, 8, 1, 1, 1, 2, 1, 2};
    for (int n = 0; n < 8; n++) m_bins[0][n] = 0;
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 3; c++) begin
        int a = px(v, c, r);
        int b = px(v, c+1, r);
        int l = px(v, c, r+1);
        int d = px(v, c+1, r+1);
        int gx = (b + d) - (a + l);
        int gy = (a + b) - (d + l);
        int ax = (gx < 0) ? -gx : gx;
        int ay = (gy < 0) ? -gy : gy;
        bit same = ((gx >= 0) == (gy >= 0));
        int best = -1;
        int be = 0;
        for (int n = 0; n < 8; n++) begin
          int s = (ay * k_mul[n]) / k_div[n];
          int e = (ax > s) ? ax - s : s - ax;
          bit ok = (n < 2) || ((n == 2 || n == 4 || n == 5) ? same : !same);
          if (ok && (best < 0 || e < be)) begin best = n; be = e; end
        end
        m_bins[0][best] += ax + ay;
      end
    end
    m_dir[0] = 0;
    for (int n = 1; n < 8; n++)
      if (m_bins[0][n] > m_bins[0][m_dir[0]]) m_dir[0] = n;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 4; s++) m_vld[s] = 0;
    end else begin
      for (int s = 3; s > 0; s--) begin
        m_vld[s] = m_vld[s-1];
        m_dir[s] = m_dir[s-1];
        for (int n = 0; n < 8; n++) m_bins[s][n] = m_bins[s-1][n];
      end
      m_vld[0] = int'(blk_vld_i);
      if (blk_vld_i) model_calc(blk_pix_i);
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check(int'(res_vld_o) == m_vld[3], "R8 valid timing", int'(res_vld_o), m_vld[3]);
      if (m_vld[3] != 0) begin
        for (int n = 0; n < 8; n++)
          check(bin_of(n) == m_bins[3][n], "R3 bin value", bin_of(n), m_bins[3][n]);
        check(int'(res_dir_o) == m_dir[3], "R7 best index", int'(res_dir_o), m_dir[3]);
      end
    end
  end

  task automatic put(input int c, input int r, input int v);
    vec[(r*DIM+c)*PIX_W +: PIX_W] = PIX_W'(v);
  endtask

  // Sends vec for one cycle; returns at the negedge after the result edge.
  task automatic send_one();
    @(negedge clk);
    blk_pix_i = vec;
    blk_vld_i = 1'b1;
    @(negedge clk);
    blk_vld_i = 1'b0;
    repeat (2) @(negedge clk);
    check(res_vld_o == 1'b0, "R8 no early result", int'(res_vld_o), 0);
    @(negedge clk);
    check(res_vld_o == 1'b1, "R8 result on fourth edge", int'(res_vld_o), 1);
  endtask

  task automatic expect_bins(input string req, input int b0, input int b2,
                             input int b3, input int dir);
    int exp [8] = '{b0, 0, b2, b3, 0, 0, 0, 0};
    for (int n = 0; n < 8; n++) check(bin_of(n) == exp[n], req, bin_of(n), exp[n]);
    check(int'(res_dir_o) == dir, req, int'(res_dir_o), dir);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(res_vld_o == 1'b0, "R9 reset valid", int'(res_vld_o), 0);
    for (int n = 0; n < 8; n++) check(bin_of(n) == 0, "R9 reset bin", bin_of(n), 0);
    check(res_dir_o == '0, "R9 reset index", int'(res_dir_o), 0);
    cmp_on = 1;

    // R1 R2 R5: top-left sample, opposite signs -> direction 3
    vec = '0; put(0, 0, 100); send_one();
    expect_bins("R5 opposite sign pick", 0, 0, 200, 3);
    // R1 R5: top-right sample, same signs -> direction 2
    vec = '0; put(3, 0, 100); send_one();
    expect_bins("R1 layout same sign pick", 0, 200, 0, 2);
    // R7: equal bins 2 and 3 -> lower index
    vec = '0; put(0, 0, 100); put(3, 0, 100); send_one();
    expect_bins("R7 bin tie", 0, 200, 200, 2);
    // R6: vertical edge, all errors equal -> direction 0
    vec = '0;
    for (int r = 0; r < 4; r++) begin put(2, r, 80); put(3, r, 80); end
    send_one();
    expect_bins("R6 error tie", 480, 0, 0, 0);
    // R4: |Gx| = 8|Gy| windows plus unit-slope windows
    vec = '0; put(1, 0, 45); put(1, 1, 35); send_one();
    expect_bins("R4 slope eight", 180, 70, 70, 0);

    // R10: samples without valid are ignored
    @(negedge clk);
    blk_pix_i = '1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      blk_pix_i = {NPIX{PIX_W'(i * 37)}};
      check(res_vld_o == 1'b0, "R10 no pulse when idle", int'(res_vld_o), 0);
    end
    repeat (4) @(negedge clk);
    expect_bins("R10 held result", 180, 70, 70, 0);

    // R8 R3 R4 R5: back-to-back streams of random and ramp blocks
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      blk_vld_i = (($urandom % 5) != 0);
      if (($urandom % 2) == 0) begin
        for (int p = 0; p < NPIX; p++) blk_pix_i[p*PIX_W +: PIX_W] = PIX_W'($urandom);
      end else begin
        int sx = int'($urandom % 61) - 30;
        int sy = int'($urandom % 61) - 30;
        int base = int'($urandom % 256);
        for (int r = 0; r < 4; r++)
          for (int c = 0; c < 4; c++) begin
            int v = base + c * sx + r * sy;
            v = (v < 0) ? 0 : ((v > 255) ? 255 : v);
            blk_pix_i[(r*DIM+c)*PIX_W +: PIX_W] = PIX_W'(v);
          end
      end
    end
    @(negedge clk);
    blk_vld_i = 1'b0;
    repeat (6) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule